// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block sequences the start of a multi-phase buck regulator. It counts switching-cycle ticks from power-on reset, or from the release of the enable pin. First it holds every phase output in high impedance with a zero reference. Then it drives the outputs low so the lower switches clamp the output. Then it lets the phases switch while the reference climbs one code at a time from zero to the programmed target. Once a fixed number of ticks has passed, it raises a done flag that gates the power-good monitor.

An overcurrent flag is produced upstream by comparing the averaged channel current against 165 % of nominal full scale. When that flag is raised after the start-up wait, the sequencer returns every output to high impedance. It then waits a long interval in place of the short one and restarts the ramp. This repeats for as long as the fault keeps coming back (hiccup). After done, a new target code reaches the reference directly, with no new ramp.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `pwm_mode` = 2'b00 (high impedance), `ref_code` = 0 and `ss_done` = 0.
- R2: For the first WAIT_SHORT (32) ticks after reset or enable, `pwm_mode` stays 2'b00 and `ref_code` stays 0.
- R3: For the next LOW_CYC (150) ticks, `pwm_mode` is 2'b01 (forced low) and `ref_code` stays 0.
- R4: After that, `pwm_mode` is 2'b10 (switching). `ref_code` rises by exactly 1 after every STEP_CYC (7) ticks until it equals `target_code`, and it never exceeds the target.
- R5: `ss_done` rises on the clock edge that counts tick number DONE_CYC (2048) of a normal start, and not earlier. While it is high, `pwm_mode` is 2'b10.
- R6: While `ss_done` is high, `ref_code` equals the `target_code` value sampled at the previous clock edge, with no ramp.
- R7: An overcurrent flag that is high at a clock edge outside the initial wait makes the next outputs 2'b00, 0 and done low.
- R8: After an overcurrent trip, the high-impedance wait lasts WAIT_LONG (2048) ticks. The forced-low interval and the ramp follow, and done comes at tick WAIT_LONG + DONE_CYC − WAIT_SHORT (4064).
- R9: The overcurrent flag is ignored during the wait. Each new overcurrent in a later phase starts a new long wait, without limit.
- R10: When `run_en` is low at a clock edge, the outputs return to the reset values of R1. The stretched wait is also cleared, so the next start uses the short wait.
- R11: Clock edges without `tick` do not advance the sequence, and the outputs hold their values.

Parameters: `REF_W` (8), `WAIT_SHORT` (32), `WAIT_LONG` (2048), `LOW_CYC` (150), `DONE_CYC` (2048), `STEP_CYC` (7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| run_en | input | 1 | Enable pin. Low disables the block and holds the sequence at its start |
| tick | input | 1 | One-clock pulse once per switching cycle |
| target_code | input | REF_W | Programmed reference code |
| oc_flag | input | 1 | Averaged-current overcurrent indication |
| ref_code | output | REF_W | Ramped reference code for the error amplifier |
| pwm_mode | output | 2 | 00 high impedance, 01 forced low, 10 switching |
| ss_done | output | 1 | Soft-start complete, enables power-good |

## Verification
A wrong tick counter or phase state shows up as a `pwm_mode` change that comes one or more ticks away from the 32, 182 or 2048 boundaries. The per-cycle comparison catches this on the first edge where the two disagree. A lost stretched-wait flag shows up as a forced-low phase 32 ticks after a trip instead of 2048. A wrong ramp step counter shows up in `ref_code` within one step period of the ramp start. Overcurrent in the wait, disable in mid-ramp, tick gaps, and target changes after done are each driven both directly and at random points.

// File: rtl/ss_pkg.sv
// Shared encodings for the soft-start sequencer.
package ss_pkg;
    // Requested drive style of all phase outputs.
    typedef enum logic [1:0] {
        PWM_TRI = 2'b00,
        PWM_LOW = 2'b01,
        PWM_SW  = 2'b10
    } pwm_mode_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        ST_WAIT  = 2'b00,
        ST_CLAMP = 2'b01,
        ST_RAMP  = 2'b10,
        ST_DONE  = 2'b11
    } seq_state_e;
endpackage

// File: rtl/ss_tick_counter.sv
// Counts switching-cycle ticks since the start of the current sequence.
// Assumes: clr has priority over tick; the count saturates at MAX_CNT.
module ss_tick_counter #(
    parameter int CNT_W   = 12,
    parameter int MAX_CNT = 4064
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_CNT);

    // Tick accumulation with synchronous clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick && count != LIMIT) begin
            count <= count + CNT_W'(1);
        end
    end

    // R11: without a tick or clear the count must not move.
    p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(count));
endmodule

// File: rtl/ss_phase_ctrl.sv
// Phase state machine: wait, clamp, ramp, done, plus the overcurrent trip.
// Assumes: count comes from ss_tick_counter cleared through cnt_clr;
// LOW_CYC > 0 and DONE_CYC > WAIT_SHORT + LOW_CYC.
module ss_phase_ctrl
    import ss_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WAIT_SHORT = 32,
    parameter int WAIT_LONG  = 2048,
    parameter int LOW_CYC    = 150,
    parameter int DONE_CYC   = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             oc_flag,
    input  logic [CNT_W-1:0] count,
    output seq_state_e       state,
    output logic             cnt_clr,
    output logic             zero_ref,
    output logic             follow_ref,
    output logic             ramp_act
);
    localparam int RUN_SPAN = DONE_CYC - WAIT_SHORT;

    seq_state_e       nxt;
    logic             long_q;
    logic             trip;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] wait_end;
    logic [CNT_W-1:0] clamp_end;
    logic [CNT_W-1:0] done_end;

    // Phase boundaries for the current wait length.
    always_comb begin
        cnt_nxt   = count + CNT_W'(1);
        wait_end  = long_q ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT);
        clamp_end = wait_end + CNT_W'(LOW_CYC);
        done_end  = wait_end + CNT_W'(RUN_SPAN);
    end

    // Next-phase decision, overcurrent ignored while waiting.
    always_comb begin
        trip = run_en && oc_flag && (state != ST_WAIT);
        nxt  = state;
        if (!run_en || trip) begin
            nxt = ST_WAIT;
        end else begin
            case (state)
                ST_WAIT:  if (tick && cnt_nxt == wait_end)  nxt = ST_CLAMP;
                ST_CLAMP: if (tick && cnt_nxt == clamp_end) nxt = ST_RAMP;
                ST_RAMP:  if (tick && cnt_nxt == done_end)  nxt = ST_DONE;
                default:  nxt = ST_DONE;
            endcase
        end
    end

    // Controls for counter and reference generator.
    always_comb begin
        cnt_clr    = !run_en || trip;
        zero_ref   = (nxt == ST_WAIT) || (nxt == ST_CLAMP);
        follow_ref = (nxt == ST_DONE);
        ramp_act   = (state == ST_RAMP);
    end

    // Phase register and stretched-wait flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            state  <= ST_WAIT;
            long_q <= 1'b0;
        end else begin
            state <= nxt;
            if (trip) long_q <= 1'b1;
        end
    end

    // R8: a trip always leaves the stretched wait armed.
    p_trip_arms_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (long_q && state == ST_WAIT));
    // R2: the wait never skips straight to ramp or done.
    p_wait_goes_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_CLAMP));
endmodule

// File: rtl/ss_ref_ramp.sv
// Reference generator: zero, stepped ramp toward target, or direct follow.
// Assumes: zero_ref and follow_ref are never high together.
module ss_ref_ramp #(
    parameter int REF_W    = 8,
    parameter int STEP_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             zero_ref,
    input  logic             follow_ref,
    input  logic             ramp_act,
    input  logic [REF_W-1:0] target,
    output logic [REF_W-1:0] ref_q
);
    logic step_due;

    generate
        if (STEP_CYC > 1) begin : g_divider
            localparam int SW = $clog2(STEP_CYC);
            localparam logic [SW-1:0] LAST = SW'(STEP_CYC - 1);
            logic [SW-1:0] step_cnt;

            // Tick divider that paces the ramp.
            always_ff @(posedge clk) begin
                if (!rst_n || zero_ref || follow_ref) begin
                    step_cnt <= '0;
                end else if (ramp_act && tick) begin
                    step_cnt <= (step_cnt == LAST) ? '0 : step_cnt + SW'(1);
                end
            end
            assign step_due = ramp_act && tick && (step_cnt == LAST);
        end else begin : g_every_tick
            assign step_due = ramp_act && tick;
        end
    endgenerate

    // Reference register.
    always_ff @(posedge clk) begin
        if (!rst_n || zero_ref) begin
            ref_q <= '0;
        end else if (follow_ref) begin
            ref_q <= target;
        end else if (step_due) begin
            if (ref_q < target)      ref_q <= ref_q + REF_W'(1);
            else if (ref_q > target) ref_q <= target;
        end
    end

    // R4: while ramping below target the reference moves up by at most one code.
    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_act && !zero_ref && !follow_ref && ref_q < target)
        |=> (ref_q == $past(ref_q) || ref_q == $past(ref_q) + REF_W'(1)));
endmodule

// File: rtl/softstart_seq.sv
// Soft-start and hiccup sequencer top.
// Assumes: tick is a one-clock pulse per switching cycle; oc_flag is already
// qualified against the averaged-current trip level; run_en low disables.
module softstart_seq
    import ss_pkg::*;
#(
    parameter int REF_W      = 8,
    parameter int WAIT_SHORT = 32,
    parameter int WAIT_LONG  = 2048,
    parameter int LOW_CYC    = 150,
    parameter int DONE_CYC   = 2048,
    parameter int STEP_CYC   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic [REF_W-1:0] target_code,
    input  logic             oc_flag,
    output logic [REF_W-1:0] ref_code,
    output logic [1:0]       pwm_mode,
    output logic             ss_done
);
    localparam int MAX_CNT = WAIT_LONG + DONE_CYC - WAIT_SHORT;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic [CNT_W-1:0] count;
    logic             cnt_clr;
    logic             zero_ref;
    logic             follow_ref;
    logic             ramp_act;
    seq_state_e       state;

    ss_tick_counter #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .count (count)
    );

    ss_phase_ctrl #(
        .CNT_W      (CNT_W),
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG),
        .LOW_CYC    (LOW_CYC),
        .DONE_CYC   (DONE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .tick       (tick),
        .oc_flag    (oc_flag),
        .count      (count),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .zero_ref   (zero_ref),
        .follow_ref (follow_ref),
        .ramp_act   (ramp_act)
    );

    ss_ref_ramp #(.REF_W(REF_W), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .zero_ref   (zero_ref),
        .follow_ref (follow_ref),
        .ramp_act   (ramp_act),
        .target     (target_code),
        .ref_q      (ref_code)
    );

    // Output decode from the registered phase.
    always_comb begin
        ss_done = (state == ST_DONE);
        case (state)
            ST_WAIT:  pwm_mode = PWM_TRI;
            ST_CLAMP: pwm_mode = PWM_LOW;
            default:  pwm_mode = PWM_SW;
        endcase
    end

    // R2: high impedance always comes with a zero reference.
    p_tri_ref_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == PWM_TRI) |-> (ref_code == '0));
    // R5: done only while switching.
    p_done_switching_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (pwm_mode == PWM_SW));
    // R6: after done the reference tracks the previous target.
    p_follow_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && run_en && !oc_flag) |=> (ref_code == $past(target_code)));
    // R7: overcurrent outside the wait forces high impedance.
    p_oc_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && oc_flag && pwm_mode != PWM_TRI)
        |=> (pwm_mode == PWM_TRI && ref_code == '0 && !ss_done));
    // R10: disable returns to the idle outputs.
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pwm_mode == PWM_TRI && ref_code == '0 && !ss_done));
endmodule

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W = 8;
    localparam int WS = 32;
    localparam int WL = 2048;
    localparam int LC = 150;
    localparam int DC = 2048;
    localparam int SC = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b1;
    logic             tick = 1'b0;
    logic [REF_W-1:0] target_code = '0;
    logic             oc_flag = 1'b0;
    logic [REF_W-1:0] ref_code;
    logic [1:0]       pwm_mode;
    logic             ss_done;

    int checks = 0;
    int errors = 0;
    int m_n = 0;
    bit m_long = 0;
    int m_ref = 0;

    softstart_seq #(
        .REF_W(REF_W), .WAIT_SHORT(WS), .WAIT_LONG(WL),
        .LOW_CYC(LC), .DONE_CYC(DC), .STEP_CYC(SC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .target_code(target_code), .oc_flag(oc_flag),
        .ref_code(ref_code), .pwm_mode(pwm_mode), .ss_done(ss_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int wait_of(bit lg);
        return lg ? WL : WS;
    endfunction

    function automatic int done_of(bit lg);
        return wait_of(lg) + DC - WS;
    endfunction

    // 0 wait, 1 clamp, 2 ramp, 3 done
    function automatic int phase_of(int n, bit lg);
        if (n < wait_of(lg)) return 0;
        if (n < wait_of(lg) + LC) return 1;
        if (n < done_of(lg)) return 2;
        return 3;
    endfunction

    function automatic int mode_of(int ph);
        return (ph == 0) ? 0 : (ph == 1) ? 1 : 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors <= 40)
                $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, update the model at the edge, compare at the negedge.
    task automatic cyc(bit tk, bit oc);
        int ph;
        int ph2;
        int steps;
        string tag;
        tick = tk;
        oc_flag = oc;
        @(posedge clk);
        ph = phase_of(m_n, m_long);
        if (!rst_n || !run_en) begin
            m_n = 0;
            m_long = 0;
        end else if (oc && ph != 0) begin
            m_n = 0;
            m_long = 1;
        end else if (tk && m_n < done_of(m_long)) begin
            m_n++;
        end
        ph2 = phase_of(m_n, m_long);
        if (ph2 < 2) m_ref = 0;
        else if (ph2 == 3) m_ref = int'(target_code);
        else begin
            steps = (m_n - wait_of(m_long) - LC) / SC;
            m_ref = (steps > int'(target_code)) ? int'(target_code) : steps;
        end
        @(negedge clk);
        tag = (ph2 == 0) ? (m_long ? "R8" : "R2") : (ph2 == 1) ? "R3" : (ph2 == 2) ? "R4" : "R6";
        check({tag, " mode"}, int'(pwm_mode), mode_of(ph2));
        check({tag, " ref"}, int'(ref_code), m_ref);
        check("R5 done", int'(ss_done), (ph2 == 3) ? 1 : 0);
    endtask

    task automatic run_ticks(int k);
        for (int i = 0; i < k; i++) cyc(1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        rst_n = 1'b0;
        target_code = 8'd200;
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        check("R1 mode", int'(pwm_mode), 0);
        check("R1 ref", int'(ref_code), 0);
        check("R1 done", int'(ss_done), 0);
        rst_n = 1'b1;

        // Normal start, explicit boundaries.
        run_ticks(31);
        check("R2 still tri at 31", int'(pwm_mode), 0);
        run_ticks(1);
        check("R3 low at 32", int'(pwm_mode), 1);
        // R11: tick gap during clamp
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0);
        check("R11 hold mode", int'(pwm_mode), 1);
        check("R11 hold ref", int'(ref_code), 0);
        run_ticks(149);
        check("R3 low at 181", int'(pwm_mode), 1);
        run_ticks(1);
        check("R4 switching at 182", int'(pwm_mode), 2);
        run_ticks(7);
        check("R4 first step", int'(ref_code), 1);
        run_ticks(2047 - 189);
        check("R5 not done at 2047", int'(ss_done), 0);
        check("R4 reached target", int'(ref_code), 200);
        run_ticks(1);
        check("R5 done at 2048", int'(ss_done), 1);

        // R6: target change after done.
        target_code = 8'd37;
        cyc(1'b0, 1'b0);
        check("R6 direct follow", int'(ref_code), 37);
        check("R6 still done", int'(ss_done), 1);

        // R7: overcurrent in done.
        cyc(1'b0, 1'b1);
        check("R7 tri", int'(pwm_mode), 0);
        check("R7 done low", int'(ss_done), 0);

        // R8/R9: long wait, overcurrent inside it ignored.
        target_code = 8'd255;
        run_ticks(100);
        cyc(1'b1, 1'b1);
        run_ticks(WL - 102);
        check("R9 wait unaffected", int'(pwm_mode), 0);
        run_ticks(1);
        check("R8 clamp after long wait", int'(pwm_mode), 1);
        run_ticks(LC + 300);
        check("R4 ramp on retry", int'(pwm_mode), 2);
        // R9: repeat trip during ramp of the retry
        cyc(1'b1, 1'b1);
        check("R9 repeated trip", int'(pwm_mode), 0);
        run_ticks(WL + LC + 10);

        // R10: disable mid-ramp, then short wait again.
        run_en = 1'b0;
        cyc(1'b1, 1'b0);
        check("R10 tri", int'(pwm_mode), 0);
        check("R10 ref", int'(ref_code), 0);
        run_en = 1'b1;
        run_ticks(WS);
        check("R10 short wait restored", int'(pwm_mode), 1);
        run_ticks(DC);
        check("R4 max target reached", int'(ref_code), 255);

        // Random phase.
        for (int it = 0; it < 30; it++) begin
            int len;
            len = 100 + int'($urandom_range(2900));
            for (int c = 0; c < len; c++) begin
                int ph;
                bit tk;
                bit oc;
                ph = phase_of(m_n, m_long);
                if ((ph == 0 || ph == 3) && $urandom_range(60) == 0)
                    target_code = REF_W'($urandom_range(255));
                run_en = ($urandom_range(1500) == 0) ? 1'b0 : 1'b1;
                tk = ($urandom_range(3) != 0);
                oc = ($urandom_range(500) == 0);
                cyc(tk, oc);
            end
        end
        run_en = 1'b1;
        finish_run();
    end
endmodule